// File: doc/BRIEF.md
# I2C Downstream Bus Recovery Sequencer

This block returns a downstream I2C segment to a clean idle state before a newly selected upstream controller is connected to it. When the channel selector asks for a switch with recovery enabled, it pulses `start_i` and names the requesting channel. The sequencer then toggles SCL through nine clock pulses and one acknowledge clock with SDA released. That acknowledge clock reads as a not-acknowledge to any target that was part-way through a byte. It then closes with a STOP condition.

The block only produces drive-low enables for SCL and SDA, meant for open-drain pads. Every SCL low or high phase, and each of the two STOP phases, lasts `div_i + 1` system clock cycles. The value of `div_i` is captured when the trigger is accepted. The new channel's connection enable changes only when the sequence completes. In that same cycle the requesting channel gets a one-cycle interrupt and a done pulse is raised.

Top module: `brs_recovery_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy_o`, `scl_low_o`, `sda_low_o` and `done_o` are 0, and `irq_o` and `conn_o` are all zeros, so no channel is connected.
- R2: A `start_i` high at a clock edge while `busy_o` is 0 is accepted. From the next cycle, `busy_o` is 1 and `scl_low_o` is 1.
- R3: After acceptance, with L = `div_i` + 1 (the value at acceptance), SCL makes nine low/high pulses, each phase L cycles long and starting with a low phase, while `sda_low_o` stays 0.
- R4: A tenth low/high SCL pulse, the acknowledge clock, follows with `sda_low_o` still 0, which signals a not-acknowledge.
- R5: The STOP follows the acknowledge clock. For L cycles SCL and SDA are both driven low. Then for L cycles SCL is released while SDA stays low. Then SDA is released, so SDA rises while SCL is high.
- R6: `done_o` is 1 for exactly one cycle, 22·L cycles after the first busy cycle, and `busy_o` is 0 in that cycle.
- R7: In the done cycle only, `irq_o` is one-hot, with bit k set for the requesting channel k. It is 0 in all other cycles.
- R8: `conn_o` changes only in the done cycle, when it becomes one-hot for the requesting channel. At all other times it holds its value.
- R9: A `start_i` that arrives while `busy_o` is 1 is ignored. Neither its channel nor its divider affects the running sequence or the channel that gets connected.
- R10: A change of `div_i` after acceptance does not alter the phase length of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery request from the selector |
| req_ch_i | input | $clog2(NCH) | Index of the requesting upstream channel |
| div_i | input | DIV_W | Phase length minus one, in system cycles |
| scl_low_o | output | 1 | Drive downstream SCL low when 1 |
| sda_low_o | output | 1 | Drive downstream SDA low when 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | NCH | Completion interrupt, one bit per upstream channel |
| conn_o | output | NCH | One-hot enable of the connected upstream channel |

## Verification
The trigger is accepted at one edge, and the first busy cycle with SCL low follows that edge. Cycle c after acceptance therefore sits in phase c/L. The done, interrupt and connection changes all appear together in cycle 22·L, and the block is back to idle in cycle 22·L+1. The bench drives each input just after a falling edge and compares every output against a function of c, L and the channel in every cycle from c = 0 to c = 22·L+1. Stray triggers and divider changes are injected mid-sequence so that any effect they had would show up in those same per-cycle comparisons.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLK_LO = 3'd1,
    ST_CLK_HI = 3'd2,
    ST_STP_LO = 3'd3,
    ST_STP_HI = 3'd4
  } brs_state_e;

  // SCL is pulled low in the clock-low phase and in the first STOP phase
  function automatic logic pulls_scl(brs_state_e s);
    return (s == ST_CLK_LO) || (s == ST_STP_LO);
  endfunction

  // SDA is pulled low only across the two STOP phases
  function automatic logic pulls_sda(brs_state_e s);
    return (s == ST_STP_LO) || (s == ST_STP_HI);
  endfunction

endpackage

// File: rtl/brs_phase_timer.sv
`timescale 1ns/1ps
module brs_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             phase_end_o
);

  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign phase_end_o = run_i && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lim_q <= div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      if (phase_end_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/brs_seq_fsm.sv
`timescale 1ns/1ps
module brs_seq_fsm
  import brs_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic phase_end_i,
  output logic busy_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic done_o,
  output logic finish_o
);

  localparam int TOTAL = NUM_PULSES + 1;
  localparam int PC_W  = $clog2(TOTAL + 1);

  brs_state_e      st_q, st_d;
  logic [PC_W-1:0] pcnt_q;
  logic            last_pulse;

  assign last_pulse = (pcnt_q == PC_W'(TOTAL - 1));
  assign finish_o   = (st_q == ST_STP_HI) && phase_end_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (accept_i)    st_d = ST_CLK_LO;
      ST_CLK_LO: if (phase_end_i) st_d = ST_CLK_HI;
      ST_CLK_HI: if (phase_end_i) st_d = last_pulse ? ST_STP_LO : ST_CLK_LO;
      ST_STP_LO: if (phase_end_i) st_d = ST_STP_HI;
      ST_STP_HI: if (phase_end_i) st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pcnt_q    <= '0;
      busy_o    <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      busy_o    <= (st_d != ST_IDLE);
      scl_low_o <= pulls_scl(st_d);
      sda_low_o <= pulls_sda(st_d);
      done_o    <= finish_o;
      if (accept_i)
        pcnt_q <= '0;
      else if ((st_q == ST_CLK_HI) && phase_end_i)
        pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/brs_channel_grant.sv
`timescale 1ns/1ps
module brs_channel_grant #(
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept_i,
  input  logic [$clog2(NCH)-1:0] req_ch_i,
  input  logic                   finish_i,
  output logic [NCH-1:0]         irq_o,
  output logic [NCH-1:0]         conn_o
);

  localparam int CH_W = $clog2(NCH);

  logic [CH_W-1:0] owner_q;
  logic [NCH-1:0]  owner_hot;

  for (genvar g = 0; g < NCH; g++) begin : g_hot
    assign owner_hot[g] = (owner_q == CH_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      irq_o   <= '0;
      conn_o  <= '0;
    end else begin
      if (accept_i) owner_q <= req_ch_i;
      if (finish_i) begin
        irq_o  <= owner_hot;
        conn_o <= owner_hot;
      end else begin
        irq_o  <= '0;
      end
    end
  end

endmodule

// File: rtl/brs_recovery_top.sv
`timescale 1ns/1ps
module brs_recovery_top #(
  parameter int NCH        = 2,
  parameter int DIV_W      = 8,
  parameter int NUM_PULSES = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [$clog2(NCH)-1:0] req_ch_i,
  input  logic [DIV_W-1:0]       div_i,
  output logic                   scl_low_o,
  output logic                   sda_low_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NCH-1:0]         irq_o,
  output logic [NCH-1:0]         conn_o
);

  logic accept;
  logic phase_end;
  logic finish;

  assign accept = start_i && !busy_o;

  brs_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .div_i      (div_i),
    .run_i      (busy_o),
    .phase_end_o(phase_end)
  );

  brs_seq_fsm #(.NUM_PULSES(NUM_PULSES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .phase_end_i(phase_end),
    .busy_o     (busy_o),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .done_o     (done_o),
    .finish_o   (finish)
  );

  brs_channel_grant #(.NCH(NCH)) u_grant (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .req_ch_i (req_ch_i),
    .finish_i (finish),
    .irq_o    (irq_o),
    .conn_o   (conn_o)
  );

endmodule

// File: rtl/brs_checker.sv
`timescale 1ns/1ps
module brs_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           scl_low_o,
  input logic           sda_low_o,
  input logic           busy_o,
  input logic           done_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] conn_o
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_o && !scl_low_o && !sda_low_o && !done_o && irq_o == '0 && conn_o == '0));

  a_r2_start_pulls_scl: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> scl_low_o);

  a_r3_sda_only_busy: assert property (@(posedge clk) disable iff (rst)
    sda_low_o |-> busy_o);

  a_r5_sda_grab_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> scl_low_o);

  a_r5_stop_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_low_o) |-> (!scl_low_o && $past(!scl_low_o)));

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_irq_onehot_done: assert property (@(posedge clk) disable iff (rst)
    (irq_o != '0) |-> (done_o && $countones(irq_o) == 1));

  a_r8_conn_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(conn_o) |-> done_o);

endmodule

bind brs_recovery_top brs_checker #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_low_o(scl_low_o),
  .sda_low_o(sda_low_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .irq_o    (irq_o),
  .conn_o   (conn_o)
);

// File: tb/sim_brs_recovery_top.sv
`timescale 1ns/1ps
module sim_brs_recovery_top;

  localparam int NCH   = 2;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [0:0]       req_ch_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic             scl_low_o, sda_low_o, busy_o, done_o;
  logic [NCH-1:0]   irq_o, conn_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;

  always #2.5 clk = ~clk;

  brs_recovery_top #(.NCH(NCH), .DIV_W(DIV_W), .NUM_PULSES(9)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .req_ch_i(req_ch_i), .div_i(div_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o),
    .irq_o(irq_o), .conn_o(conn_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int hot(int ch);
    return 1 << ch;
  endfunction

  // expected SCL pull for cycle c of a sequence with phase length L
  function automatic int exp_scl(int c, int L);
    if (c < 20 * L) return ((c / L) % 2 == 0) ? 1 : 0;
    if (c < 21 * L) return 1;
    return 0;
  endfunction

  function automatic int exp_sda(int c, int L);
    return (c >= 20 * L && c < 22 * L) ? 1 : 0;
  endfunction

  task automatic run_seq(int dv, int ch, bit stray);
    int L = dv + 1;
    int prev;
    @(negedge clk);
    prev = int'(conn_o);
    start_i  = 1'b1;
    div_i    = DIV_W'(dv);
    req_ch_i = 1'(ch);
    for (int c = 0; c <= 22 * L + 1; c++) begin
      string ctag;
      @(negedge clk);
      if (c == 0) start_i = 1'b0;
      if (stray && c == 2) begin   // R9 stray trigger, R10 divider change
        start_i  = 1'b1;
        req_ch_i = 1'(ch ^ 1);
        div_i    = DIV_W'(dv ^ 3);
      end
      if (stray && c == 3) start_i = 1'b0;
      ctag = (c < 18 * L) ? "R3" : (c < 20 * L) ? "R4" : "R5";
      if (stray) ctag = "R10";
      chk(c == 0 ? "R2" : "R6", "busy", int'(busy_o), (c < 22 * L) ? 1 : 0);
      chk(ctag, "scl_low", int'(scl_low_o), exp_scl(c, L));
      chk(ctag, "sda_low", int'(sda_low_o), exp_sda(c, L));
      chk("R6", "done", int'(done_o), (c == 22 * L) ? 1 : 0);
      chk(stray ? "R9" : "R7", "irq", int'(irq_o), (c == 22 * L) ? hot(ch) : 0);
      chk(stray ? "R9" : "R8", "conn", int'(conn_o), (c >= 22 * L) ? hot(ch) : prev);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1c2d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state while held
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "scl_low", int'(scl_low_o), 0);
    chk("R1", "sda_low", int'(sda_low_o), 0);
    chk("R1", "conn", int'(conn_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    chk("R1", "busy while reset", int'(busy_o), 0);
    start_i = 1'b0;
    rst     = 1'b0;
    @(negedge clk);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "irq", int'(irq_o), 0);

    run_seq(0, 0, 1'b0);
    run_seq(3, 1, 1'b0);
    run_seq(0, 1, 1'b1);
    run_seq(4, 0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      int dv = int'($urandom_range(0, 7));
      int ch = int'($urandom_range(0, 1));
      bit st = 1'($urandom_range(0, 1));
      repeat (int'($urandom_range(0, 3))) begin
        @(negedge clk);
        chk("R8", "idle conn held", int'(conn_o), int'(conn_o));
        chk("R7", "idle irq", int'(irq_o), 0);
      end
      run_seq(dv, ch, st);
    end

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule